// File: doc/BRIEF.md
# SPI NOR Flash Command Controller

This block is a hardware master that sits between a host and a serial NOR flash device. The host presents one request at a time: an operation (read, program or sector erase), a start address and a byte count. The block checks that the request is legal and turns it into a series of SPI command frames. Program and erase data move through byte streams with valid/ready handshakes. When the request finishes, a one-cycle completion pulse reports an error flag and the number of bytes handled.

Before every read, every program page and every sector erase, the block polls the flash status byte until the write-in-progress bit clears. It gives up after a parameterised number of attempts. Programming is cut into chunks that never cross a page boundary. Erase walks the range one sector at a time. Each program and erase frame is preceded by its own one-byte write-enable frame. On the flash side the block is a mode-0 SPI master: the clock idles low, data is sampled on the rising edge and changed on the falling edge, bytes go out most significant bit first, and the clock runs at the system clock divided by twice `CLK_DIV`.

Back-pressure rules: a read byte stays on `rd_data` with `rd_valid` high until the host takes it with `rd_ready`, and the SPI clock stops meanwhile. During program data the block raises `wr_ready` only when it is ready to shift a byte, and it waits with SPI clock idle while `wr_valid` is low. No byte is lost or repeated in either direction.

Top module: `spi_nor_cmd_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sck` is low, `req_ready` is high and `done` is low.
- R2: SPI bytes are sent most significant bit first in mode 0. The clock is low whenever chip select is high, and chip select goes high for at least one system clock between two frames.
- R3: A read is one frame: opcode 0x03, then a 24-bit address most significant byte first, then the requested number of bytes clocked in under the same chip-select assertion. Each byte is handed out on `rd_data`, and it is held stable while `rd_valid` is high and `rd_ready` is low.
- R4: Before each read frame, each program page and each sector erase, the block sends status frames (opcode 0x05 followed by one byte clocked in). It repeats them until bit 0 of the returned byte is 0.
- R5: If `POLL_LIMIT` consecutive status frames all return bit 0 set, the request ends with `done_err` high. `done_bytes` then holds the bytes completed by earlier pages or sectors, and no further frames are sent.
- R6: A separate one-byte frame with opcode 0x06 is sent after each successful status wait and before every program frame and every erase frame. A read is not preceded by one.
- R7: A program request is sent as frames with opcode 0x02 and an address. The first frame carries the bytes up to the next 256-byte page boundary, and each later frame carries at most 256 bytes. The data bytes come from the write stream in order.
- R8: An erase request sends one frame per sector: opcode 0xD8 and the sector address, with no data. It is rejected if the start address or the length is not a multiple of `SECTOR_BYTES`.
- R9: Op codes are 0 read, 1 program, 2 erase and 3 invalid. Code 3, and any request whose address plus length exceeds `SECTOR_BYTES*NUM_SECTORS`, completes with `done_err` high, `done_bytes` 0 and no chip-select assertion. A request ending exactly at the device end is accepted.
- R10: A request of length zero completes with no error, `done_bytes` 0 and no SPI traffic.
- R11: `done` is high for exactly one cycle per request. `done_bytes` then equals the bytes read, programmed or erased. `req_ready` is high only while the block is idle, never while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte accepted when valid |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte present |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request failed or was rejected |
| done_bytes | output | LEN_W | Bytes handled by the request |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The assertions assume a host that keeps `rd_ready` low whenever it wants a byte held. They also assume the host presents write data only during program requests, and a flash that returns status and read bytes on the falling clock edge. The bench flash model changes `spi_miso` only on falling `spi_sck` edges and logs every frame it sees. The host drivers change requests and stream signals on falling system clock edges and pause both streams at fixed intervals, so every handshake rule is exercised without driving an input the block cannot interpret.

// File: rtl/spinor_pkg.sv
package spinor_pkg;
  localparam int FRAME_AW = 24;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_ERASE  = 8'hD8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_GAP,
    ST_FIN
  } st_e;

  typedef enum logic [1:0] {
    FK_STAT,
    FK_WREN,
    FK_CMD
  } fk_e;

  function automatic logic [7:0] op_code(op_e op);
    case (op)
      OP_PROG:  return OPC_PROG;
      OP_ERASE: return OPC_ERASE;
      default:  return OPC_READ;
    endcase
  endfunction
endpackage

// File: rtl/spinor_shift.sv
module spinor_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= 8'h00;
      sck     <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_q    <= 8'h00;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        tx_q  <= tx_byte;
        div_q <= '0;
        bit_q <= '0;
        sck   <= 1'b0;
      end else if (busy) begin
        if (div_q == DW'(CLK_DIV - 1)) begin
          div_q <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_q == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mosi = tx_q[7];

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/spinor_check.sv
module spinor_check #(
  parameter int SECTOR_BYTES = 65536,
  parameter int DEV_BYTES    = 2097152,
  parameter int AW           = 24,
  parameter int LW           = 22
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  output logic          legal
);
  import spinor_pkg::*;
  localparam int SL = $clog2(SECTOR_BYTES);
  localparam int SW = ((AW > LW) ? AW : LW) + 1;

  logic [SW-1:0] end_sum;
  logic          bad_range;
  logic          misalign;

  always_comb begin
    end_sum   = SW'(addr) + SW'(len);
    bad_range = end_sum > SW'(DEV_BYTES);
    misalign  = (addr[SL-1:0] != '0) || (len[SL-1:0] != '0);
    legal     = (op_e'(op) != OP_NONE) && !bad_range &&
                !((op_e'(op) == OP_ERASE) && misalign);
  end
endmodule

// File: rtl/spi_nor_cmd_ctrl.sv
module spi_nor_cmd_ctrl #(
  parameter int CLK_DIV      = 2,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 65536,
  parameter int NUM_SECTORS  = 32,
  parameter int POLL_LIMIT   = 100000,
  localparam int DEV_BYTES   = SECTOR_BYTES * NUM_SECTORS,
  localparam int LEN_W       = $clog2(DEV_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             done_err,
  output logic [LEN_W-1:0] done_bytes,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  import spinor_pkg::*;

  localparam int AW    = FRAME_AW;
  localparam int LW    = LEN_W;
  localparam int PG_LG = $clog2(PAGE_BYTES);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  st_e            st;
  fk_e            kind;
  op_e            op_q;
  logic [2:0]     hdr_idx;
  logic [2:0]     hdr_total;
  logic [LW-1:0]  data_cnt;
  logic [LW-1:0]  left_q;
  logic [LW-1:0]  unit_len;
  logic [LW-1:0]  data_len;
  logic [LW-1:0]  page_room;
  logic [LW-1:0]  bytes_q;
  logic [AW-1:0]  cur_addr;
  logic [PW-1:0]  poll_cnt;
  logic [DW-1:0]  gap_cnt;
  logic           inflight, rd_hold, stat_busy, err_q;
  logic [7:0]     rd_q, tx_b, sh_rx;
  logic           sh_start, sh_busy, sh_done;
  logic           in_hdr, in_data, frame_end, req_legal;

  spinor_check #(
    .SECTOR_BYTES(SECTOR_BYTES), .DEV_BYTES(DEV_BYTES), .AW(AW), .LW(LW)
  ) u_check (
    .op(req_op), .addr(req_addr), .len(req_len), .legal(req_legal)
  );

  spinor_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_b),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_byte(sh_rx),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  // size of the current page, sector or read burst
  always_comb begin
    page_room = LW'(PAGE_BYTES) - LW'(cur_addr[PG_LG-1:0]);
    case (op_q)
      OP_PROG:  unit_len = (left_q < page_room) ? left_q : page_room;
      OP_ERASE: unit_len = LW'(SECTOR_BYTES);
      default:  unit_len = left_q;
    endcase
    data_len = (op_q == OP_ERASE) ? '0 : unit_len;
    case (kind)
      FK_STAT: hdr_total = 3'd2;
      FK_WREN: hdr_total = 3'd1;
      default: hdr_total = 3'd4;
    endcase
    in_hdr  = hdr_idx < hdr_total;
    in_data = (kind == FK_CMD) && !in_hdr && (data_cnt < data_len);
  end

  always_comb begin
    tx_b = 8'h00;
    case (kind)
      FK_STAT: if (hdr_idx == 3'd0) tx_b = OPC_STATUS;
      FK_WREN: tx_b = OPC_WREN;
      default: begin
        if (in_hdr) begin
          case (hdr_idx)
            3'd0:    tx_b = op_code(op_q);
            3'd1:    tx_b = cur_addr[23:16];
            3'd2:    tx_b = cur_addr[15:8];
            default: tx_b = cur_addr[7:0];
          endcase
        end else if (op_q == OP_PROG) begin
          tx_b = wr_data;
        end
      end
    endcase
  end

  assign sh_start  = (st == ST_FRAME) && !inflight && !sh_busy &&
                     (in_hdr || (in_data && ((op_q == OP_PROG) ? wr_valid : !rd_hold)));
  assign wr_ready  = (st == ST_FRAME) && !inflight && in_data && (op_q == OP_PROG);
  assign frame_end = (st == ST_FRAME) && !inflight && !in_hdr && !in_data && !rd_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= FK_STAT;
      op_q      <= OP_READ;
      hdr_idx   <= '0;
      data_cnt  <= '0;
      left_q    <= '0;
      bytes_q   <= '0;
      cur_addr  <= '0;
      poll_cnt  <= '0;
      gap_cnt   <= '0;
      inflight  <= 1'b0;
      rd_hold   <= 1'b0;
      stat_busy <= 1'b0;
      err_q     <= 1'b0;
      rd_q      <= 8'h00;
    end else begin
      if (rd_hold && rd_ready) rd_hold <= 1'b0;
      if (sh_start) inflight <= 1'b1;
      if (sh_done) begin
        inflight <= 1'b0;
        if (in_hdr) begin
          hdr_idx <= hdr_idx + 3'd1;
          if (kind == FK_STAT && hdr_idx == 3'd1) stat_busy <= sh_rx[0];
        end else begin
          data_cnt <= data_cnt + 1'b1;
          if (op_q == OP_READ) begin
            rd_q    <= sh_rx;
            rd_hold <= 1'b1;
          end
        end
      end
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q     <= op_e'(req_op);
          cur_addr <= req_addr;
          left_q   <= req_len;
          bytes_q  <= '0;
          poll_cnt <= '0;
          err_q    <= !req_legal;
          if (!req_legal || req_len == '0) begin
            st <= ST_FIN;
          end else begin
            st       <= ST_FRAME;
            kind     <= FK_STAT;
            hdr_idx  <= '0;
            data_cnt <= '0;
          end
        end
        ST_FRAME: if (frame_end) begin
          st      <= ST_GAP;
          gap_cnt <= '0;
        end
        ST_GAP: if (gap_cnt == DW'(CLK_DIV - 1)) begin
          st       <= ST_FRAME;
          hdr_idx  <= '0;
          data_cnt <= '0;
          case (kind)
            FK_STAT: begin
              if (stat_busy) begin
                if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                  st    <= ST_FIN;
                  err_q <= 1'b1;
                end else begin
                  poll_cnt <= poll_cnt + 1'b1;
                end
              end else begin
                poll_cnt <= '0;
                kind     <= (op_q == OP_READ) ? FK_CMD : FK_WREN;
              end
            end
            FK_WREN: kind <= FK_CMD;
            default: begin
              bytes_q  <= bytes_q + unit_len;
              cur_addr <= cur_addr + AW'(unit_len);
              left_q   <= left_q - unit_len;
              kind     <= FK_STAT;
              if (left_q == unit_len) st <= ST_FIN;
            end
          endcase
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign spi_cs_n   = (st != ST_FRAME);
  assign rd_valid   = rd_hold;
  assign rd_data    = rd_q;
  assign done       = (st == ST_FIN);
  assign done_err   = err_q;
  assign done_bytes = bytes_q;

  // R2
  cs_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PW'(POLL_LIMIT));
  // R7
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_cs_n);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);
endmodule

// File: tb/spi_nor_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module spi_nor_cmd_ctrl_tb;
  localparam int LW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [1:0]    req_op = 0;
  logic [23:0]   req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic          wr_valid = 0, wr_ready;
  logic [7:0]    wr_data = 0;
  logic          rd_valid, rd_ready = 1;
  logic [7:0]    rd_data;
  logic          done, done_err;
  logic [LW-1:0] done_bytes;
  logic          spi_cs_n, spi_sck, spi_mosi;
  logic          spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;

  spi_nor_cmd_ctrl #(.POLL_LIMIT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_err(done_err), .done_bytes(done_bytes),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model ----------------
  int          busy_after = 2;
  bit          busy_forever = 0;
  int          m_bits = 0;
  logic [7:0]  m_sh = 0, m_op = 0;
  logic [23:0] m_addr = 0;
  int          m_busy_left = 0;
  int          m_wsum = 0;
  int          f_n = 0;
  int          m_csfalls = 0;
  logic [7:0]  f_op [0:63];
  logic [23:0] f_addr [0:63];
  int          f_len [0:63];

  function automatic logic [7:0] rdpat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] wpat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(negedge spi_cs_n) m_csfalls++;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (m_bits > 0) begin
        if (f_n < 64) begin
          f_op[f_n] = m_op; f_addr[f_n] = m_addr; f_len[f_n] = m_bits / 8;
        end
        f_n++;
        if (m_op == 8'h05 && m_busy_left > 0) m_busy_left--;
        if (m_op == 8'h02 || m_op == 8'hD8) m_busy_left = busy_after;
      end
      m_bits = 0;
    end else begin
      m_sh = {m_sh[6:0], spi_mosi};
      m_bits++;
      if (m_bits % 8 == 0) begin
        if (m_bits == 8) m_op = m_sh;
        else if (m_bits <= 32) m_addr = {m_addr[15:0], m_sh};
        else if (m_op == 8'h02) m_wsum += m_sh;
      end
    end
  end

  always @(negedge spi_sck) begin
    int bidx; int bpos; logic [7:0] resp;
    bidx = m_bits / 8; bpos = 7 - (m_bits % 8); resp = 8'h00;
    if (m_op == 8'h05 && bidx >= 1) resp = {7'b0, busy_forever || m_busy_left > 0};
    else if (m_op == 8'h03 && bidx >= 4) resp = rdpat(m_addr + 24'(bidx - 4));
    spi_miso = resp[bpos];
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input logic [LW-1:0] n);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_len = n;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output logic e, output logic [LW-1:0] b);
    while (!done) @(negedge clk);
    e = done_err; b = done_bytes;
    @(negedge clk);
    chk("R11 done width", {31'b0, done}, 0);
  endtask

  task automatic exp_frame(input string tag, input int idx, input logic [7:0] op,
                           input int len, input logic [23:0] a, input bit ca);
    chk({tag, " op"}, {24'b0, f_op[idx]}, {24'b0, op});
    chk({tag, " len"}, f_len[idx], len);
    if (ca) chk({tag, " addr"}, {8'b0, f_addr[idx]}, {8'b0, a});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1 cs_n", {31'b0, spi_cs_n}, 1);
    chk("R1 sck", {31'b0, spi_sck}, 0);
    chk("R1 req_ready", {31'b0, req_ready}, 1);
    chk("R1 done", {31'b0, done}, 0);
  endtask

  task automatic t_reject;
    logic e; logic [LW-1:0] b; int cs0;
    cs0 = m_csfalls;
    issue(2'd2, 24'h000100, 22'h010000); wait_done(e, b);
    chk("R8 misaligned addr err", {31'b0, e}, 1);
    issue(2'd2, 24'h000000, 22'h008000); wait_done(e, b);
    chk("R8 misaligned len err", {31'b0, e}, 1);
    issue(2'd0, 24'h1FFFF0, 22'h000020); wait_done(e, b);
    chk("R9 read past end err", {31'b0, e}, 1);
    issue(2'd1, 24'h1FFFFF, 22'h000002); wait_done(e, b);
    chk("R9 program past end err", {31'b0, e}, 1);
    chk("R9 bytes zero", {10'b0, b}, 0);
    issue(2'd3, 24'h000000, 22'h000004); wait_done(e, b);
    chk("R9 invalid op err", {31'b0, e}, 1);
    chk("R9 no chip select", m_csfalls - cs0, 0);
  endtask

  task automatic t_zero;
    logic e; logic [LW-1:0] b; int cs0;
    cs0 = m_csfalls;
    issue(2'd0, 24'h000040, 22'h0); wait_done(e, b);
    chk("R10 read err", {31'b0, e}, 0);
    chk("R10 read bytes", {10'b0, b}, 0);
    issue(2'd1, 24'h000040, 22'h0); wait_done(e, b);
    chk("R10 program err", {31'b0, e}, 0);
    chk("R10 no traffic", m_csfalls - cs0, 0);
  endtask

  task automatic t_read(input logic [23:0] a, input int n, input bit frames);
    logic e; logic [LW-1:0] b; int base;
    base = f_n;
    issue(2'd0, a, LW'(n));
    fork
      begin
        int got = 0; int k = 0;
        while (got < n) begin
          @(negedge clk);
          rd_ready = (k % 3 != 1); k++;
          if (rd_valid && rd_ready) begin
            chk("R3 read data", {24'b0, rd_data}, {24'b0, rdpat(a + 24'(got))});
            got++;
          end
        end
      end
      wait_done(e, b);
    join
    rd_ready = 1;
    chk("R3 read err", {31'b0, e}, 0);
    chk("R11 read bytes", {10'b0, b}, n);
    if (frames) begin
      chk("R3 frame count", f_n - base, 2);
      exp_frame("R4 status before read", base, 8'h05, 2, 0, 0);
      exp_frame("R3 read frame", base + 1, 8'h03, 4 + n, a, 1);
    end
  endtask

  task automatic t_prog;
    logic e; logic [LW-1:0] b; int base; int sum0; int exp_sum;
    base = f_n; sum0 = m_wsum; exp_sum = 0;
    for (int i = 0; i < 300; i++) exp_sum += wpat(i);
    issue(2'd1, 24'h0000F0, 22'd300);
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          if (i % 5 == 4) begin wr_valid = 0; @(negedge clk); end
          wr_valid = 1; wr_data = wpat(i);
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
        end
        wr_valid = 0;
      end
      wait_done(e, b);
    join
    chk("R7 program err", {31'b0, e}, 0);
    chk("R11 program bytes", {10'b0, b}, 300);
    chk("R7 frame count", f_n - base, 13);
    exp_frame("R4 status p0", base, 8'h05, 2, 0, 0);
    exp_frame("R6 wren p0", base + 1, 8'h06, 1, 0, 0);
    exp_frame("R7 page0", base + 2, 8'h02, 20, 24'h0000F0, 1);
    exp_frame("R4 busy poll a", base + 3, 8'h05, 2, 0, 0);
    exp_frame("R4 busy poll b", base + 5, 8'h05, 2, 0, 0);
    exp_frame("R6 wren p1", base + 6, 8'h06, 1, 0, 0);
    exp_frame("R7 page1", base + 7, 8'h02, 260, 24'h000100, 1);
    exp_frame("R6 wren p2", base + 11, 8'h06, 1, 0, 0);
    exp_frame("R7 page2", base + 12, 8'h02, 32, 24'h000200, 1);
    chk("R7 data sum", m_wsum - sum0, exp_sum);
  endtask

  task automatic t_erase;
    logic e; logic [LW-1:0] b; int base;
    base = f_n;
    issue(2'd2, 24'h010000, 22'h020000); wait_done(e, b);
    chk("R8 erase err", {31'b0, e}, 0);
    chk("R11 erase bytes", {10'b0, b}, 32'h20000);
    chk("R8 frame count", f_n - base, 10);
    exp_frame("R4 erase poll", base + 2, 8'h05, 2, 0, 0);
    exp_frame("R6 wren s0", base + 3, 8'h06, 1, 0, 0);
    exp_frame("R8 sector0", base + 4, 8'hD8, 4, 24'h010000, 1);
    exp_frame("R6 wren s1", base + 8, 8'h06, 1, 0, 0);
    exp_frame("R8 sector1", base + 9, 8'hD8, 4, 24'h020000, 1);
  endtask

  task automatic t_timeout;
    logic e; logic [LW-1:0] b; int base; int nstat;
    base = f_n; busy_forever = 1;
    issue(2'd2, 24'h000000, 22'h020000); wait_done(e, b);
    busy_forever = 0;
    chk("R5 timeout err", {31'b0, e}, 1);
    chk("R5 timeout bytes", {10'b0, b}, 0);
    chk("R5 poll frames", f_n - base, 8);
    nstat = 0;
    for (int i = base; i < f_n && i < 64; i++) if (f_op[i] == 8'h05) nstat++;
    chk("R5 only status frames", nstat, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reject();
    t_zero();
    t_read(24'h0123F0, 5, 1);
    t_read(24'h1FFFFC, 4, 0);
    t_prog();
    t_erase();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule